// File: doc/BRIEF.md
# Multi-Mode Output Compare Channel

This block is one output compare channel driven by an external free-running timer. A 3-bit mode value selects how the channel turns timer matches into a waveform on a single output pin. The choices are off, a one-shot rising edge, a one-shot falling edge, toggle, a single delayed pulse, a repeating pulse, and PWM with or without a fault shutdown. Each match compares the timer count against two compare values: a primary one (`cmp_r`) and a secondary one (`cmp_rs`).

The channel registers the pin level. It also raises a one-cycle interrupt pulse on the pin edges that the active mode selects, or on a falling edge of the fault input. The timer, its period logic and any register bus stay outside. The host supplies the count and a period-match strobe, and writes a new mode only while the timer is stopped.

Top module: `oc_channel`

## Requirements
- R1: A mode write (`mode_wr` high at a clock edge) is taken into `mode_q` only when `tmr_en` is low. A write made while `tmr_en` is high is ignored and leaves `mode_q` unchanged.
- R2: On an accepted write, `pin_out` is set at the same edge to a fixed level. Modes 1, 4 and 5 give 0. Mode 2 gives 1. Mode 3 keeps the current level. Modes 6 and 7 give 1 if `cmp_r` is nonzero and 0 otherwise. A write never raises `irq`.
- R3: In mode 0, `pin_oe` is low and `irq` stays low. In every other mode `pin_oe` is high.
- R4: Compare events act only while `tmr_en` is high. In mode 1, the pin goes high at the edge where `tmr_cnt == cmp_r` and then stays high. `irq` pulses for one cycle together with that rise.
- R5: In mode 2, the pin goes low on a match with `cmp_r`, and `irq` pulses with that fall.
- R6: In mode 3, the pin inverts on every match with `cmp_r`, and `irq` pulses on each inversion.
- R7: In mode 4, the pin goes high on a match with `cmp_r` and low on a later match with `cmp_rs`, once only until the mode is rewritten. `irq` pulses on the fall.
- R8: Mode 5 works like mode 4, but the high-then-low pulse repeats every time the timer passes the two values again.
- R9: In modes 6 and 7, `period_hit` loads `cmp_rs` into the active duty value and sets the pin high, or low when `cmp_rs` is zero. The pin goes low when `tmr_cnt` equals the active duty value. A change of `cmp_rs` within a period has no effect until the next `period_hit`. An accepted write loads `cmp_r` as the first duty.
- R10: Mode 6 never raises `irq`.
- R11: In mode 7, a low `fault_n` forces the pin low and sets `fault_flag` at the next edge. `irq` pulses once for each high-to-low transition of `fault_n`. The pin stays low, regardless of `period_hit`, until an accepted mode write clears the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_en | input | 1 | Timer running; gates compare events and blocks mode writes |
| tmr_cnt | input | W | Timer count |
| period_hit | input | 1 | Period-match strobe from the timer |
| mode_wr | input | 1 | Mode write strobe |
| mode_in | input | 3 | Mode value to write |
| cmp_r | input | W | Primary compare value |
| cmp_rs | input | W | Secondary compare / next duty value |
| fault_n | input | 1 | Active-low fault input |
| pin_out | output | 1 | Output pin level |
| pin_oe | output | 1 | Output drive enable (low in mode 0) |
| irq | output | 1 | One-cycle interrupt pulse |
| fault_flag | output | 1 | Latched fault in mode 7 |
| mode_q | output | 3 | Currently active mode |

## Verification
The bench re-presents a matching count after a one-shot has fired. A channel that did not latch its one-shot would rise or pulse a second time.

It changes `cmp_rs` in the middle of a PWM period. A design that read the duty value directly would cut the pulse short.

It releases the fault input and then strobes `period_hit` in mode 7. A channel that did not hold the fault would restart the waveform.

It also checks several other corner cases:
- A write attempted while the timer runs must be dropped.
- In toggle mode the pin level must carry across the write.
- Modes 6 and 7 must start low when `cmp_r` is zero.
- Matches presented with the timer stopped must not move the pin.

// File: rtl/oc_channel.sv
module oc_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tmr_en,
  input  logic [W-1:0] tmr_cnt,
  input  logic         period_hit,
  input  logic         mode_wr,
  input  logic [2:0]   mode_in,
  input  logic [W-1:0] cmp_r,
  input  logic [W-1:0] cmp_rs,
  input  logic         fault_n,
  output logic         pin_out,
  output logic         pin_oe,
  output logic         irq,
  output logic         fault_flag,
  output logic [2:0]   mode_q
);

  logic         pin_q, pin_nx;
  logic         done_q, done_nx;
  logic         flt_q, flt_nx;
  logic         fprev_q;
  logic         irq_q, irq_nx;
  logic [W-1:0] duty_q, duty_nx;

  wire accept = mode_wr && !tmr_en;
  wire hit_r  = tmr_en && (tmr_cnt == cmp_r);
  wire hit_rs = tmr_en && (tmr_cnt == cmp_rs);

  always_comb begin
    pin_nx  = pin_q;
    done_nx = done_q;
    flt_nx  = flt_q;
    duty_nx = duty_q;
    if (accept) begin
      case (mode_in)
        3'd1, 3'd4, 3'd5: pin_nx = 1'b0;
        3'd2:             pin_nx = 1'b1;
        3'd6, 3'd7:       pin_nx = (cmp_r != '0);
        default:          pin_nx = pin_q;
      endcase
      done_nx = 1'b0;
      flt_nx  = 1'b0;
      duty_nx = cmp_r;
    end else if (mode_q == 3'd7 && (!fault_n || flt_q)) begin
      pin_nx = 1'b0;
      flt_nx = 1'b1;
    end else if (tmr_en) begin
      case (mode_q)
        3'd1: if (hit_r) pin_nx = 1'b1;
        3'd2: if (hit_r) pin_nx = 1'b0;
        3'd3: if (hit_r) pin_nx = ~pin_q;
        3'd4: if (!done_q) begin
          if (hit_rs && pin_q) begin
            pin_nx  = 1'b0;
            done_nx = 1'b1;
          end else if (hit_r) pin_nx = 1'b1;
        end
        3'd5: begin
          if (hit_rs && pin_q) pin_nx = 1'b0;
          else if (hit_r)      pin_nx = 1'b1;
        end
        3'd6, 3'd7: begin
          if (period_hit) begin
            duty_nx = cmp_rs;
            pin_nx  = (cmp_rs != '0);
          end else if (tmr_cnt == duty_q) pin_nx = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    irq_nx = 1'b0;
    if (!accept) begin
      case (mode_q)
        3'd1:             irq_nx = !pin_q && pin_nx;
        3'd2, 3'd4, 3'd5: irq_nx = pin_q && !pin_nx;
        3'd3:             irq_nx = pin_q ^ pin_nx;
        3'd7:             irq_nx = fprev_q && !fault_n;
        default:          irq_nx = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= 3'd0;
      pin_q   <= 1'b0;
      done_q  <= 1'b0;
      flt_q   <= 1'b0;
      fprev_q <= 1'b1;
      irq_q   <= 1'b0;
      duty_q  <= '0;
    end else begin
      if (accept) mode_q <= mode_in;
      pin_q   <= pin_nx;
      done_q  <= done_nx;
      flt_q   <= flt_nx;
      fprev_q <= fault_n;
      irq_q   <= irq_nx;
      duty_q  <= duty_nx;
    end
  end

  assign pin_out    = pin_q;
  assign pin_oe     = (mode_q != 3'd0);
  assign irq        = irq_q;
  assign fault_flag = flt_q;

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_en |=> $stable(mode_q)); // R1
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd0) |-> !irq); // R3
  AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd1 && pin_out && !accept) |=> pin_out); // R4
  AST_RISE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd1 && $rose(irq)) |-> $rose(pin_out)); // R4
  AST_PWM_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd6) |-> !irq); // R10
  AST_FAULT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    fault_flag |-> !pin_out); // R11
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_flag && !accept) |=> fault_flag); // R11

endmodule

// File: tb/oc_channel_tb.sv
module oc_channel_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tmr_en = 1'b0;
  logic [W-1:0] tmr_cnt = '0;
  logic         period_hit = 1'b0;
  logic         mode_wr = 1'b0;
  logic [2:0]   mode_in = 3'd0;
  logic [W-1:0] cmp_r = '0;
  logic [W-1:0] cmp_rs = '0;
  logic         fault_n = 1'b1;
  logic         pin_out, pin_oe, irq, fault_flag;
  logic [2:0]   mode_q;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  oc_channel #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .tmr_cnt(tmr_cnt),
    .period_hit(period_hit), .mode_wr(mode_wr), .mode_in(mode_in),
    .cmp_r(cmp_r), .cmp_rs(cmp_rs), .fault_n(fault_n),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
    .fault_flag(fault_flag), .mode_q(mode_q)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_mode(logic [2:0] m);
    tmr_en = 1'b0; mode_wr = 1'b1; mode_in = m;
    tick();
    mode_wr = 1'b0;
  endtask

  task automatic cnt_step(int c);
    tmr_en = 1'b1; tmr_cnt = W'(c);
    tick();
  endtask

  task automatic t_reset();
    chk("R3 reset mode", mode_q, 0);
    chk("R3 reset oe", pin_oe, 0);
    chk("R3 reset pin", pin_out, 0);
    chk("R3 reset irq", irq, 0);
  endtask

  task automatic t_write_gate();
    tmr_en = 1'b1; mode_wr = 1'b1; mode_in = 3'd1;
    tick();
    mode_wr = 1'b0;
    chk("R1 write while running ignored", mode_q, 0);
    wr_mode(3'd1);
    chk("R1 write while stopped", mode_q, 1);
    chk("R2 mode1 init", pin_out, 0);
    chk("R3 oe on", pin_oe, 1);
  endtask

  task automatic t_mode1();
    cmp_r = 16'd5;
    tmr_en = 1'b0; tmr_cnt = 16'd5;
    tick();
    chk("R4 no event while stopped", pin_out, 0);
    cnt_step(3); chk("R4 no match", pin_out, 0);
    cnt_step(5); chk("R4 rise", pin_out, 1); chk("R4 irq", irq, 1);
    cnt_step(6); chk("R4 hold", pin_out, 1); chk("R4 irq one cycle", irq, 0);
    cnt_step(5); chk("R4 stays", pin_out, 1); chk("R4 no second irq", irq, 0);
  endtask

  task automatic t_mode2();
    wr_mode(3'd2);
    chk("R2 mode2 init", pin_out, 1); chk("R2 no irq on write", irq, 0);
    cnt_step(5); chk("R5 fall", pin_out, 0); chk("R5 irq", irq, 1);
    cnt_step(6); chk("R5 irq clear", irq, 0);
  endtask

  task automatic t_mode3();
    wr_mode(3'd3);
    chk("R2 mode3 keeps level", pin_out, 0);
    cnt_step(5); chk("R6 toggle up", pin_out, 1); chk("R6 irq up", irq, 1);
    cnt_step(6); chk("R6 no match", pin_out, 1); chk("R6 irq gap", irq, 0);
    cnt_step(5); chk("R6 toggle down", pin_out, 0); chk("R6 irq down", irq, 1);
    wr_mode(3'd3);
    chk("R2 mode3 keeps low", pin_out, 0);
  endtask

  task automatic t_mode4();
    cmp_r = 16'd2; cmp_rs = 16'd4;
    cnt_step(5);
    wr_mode(3'd4);
    chk("R2 mode4 init", pin_out, 0);
    cnt_step(2); chk("R7 rise", pin_out, 1); chk("R7 no irq on rise", irq, 0);
    cnt_step(4); chk("R7 fall", pin_out, 0); chk("R7 irq fall", irq, 1);
    cnt_step(2); chk("R7 once only", pin_out, 0);
    cnt_step(4); chk("R7 no repeat irq", irq, 0);
  endtask

  task automatic t_mode5();
    wr_mode(3'd5);
    chk("R2 mode5 init", pin_out, 0);
    cnt_step(2); chk("R8 rise", pin_out, 1);
    cnt_step(4); chk("R8 fall", pin_out, 0); chk("R8 irq", irq, 1);
    cnt_step(2); chk("R8 repeat rise", pin_out, 1);
    cnt_step(4); chk("R8 repeat fall", pin_out, 0); chk("R8 repeat irq", irq, 1);
  endtask

  task automatic t_pwm();
    cmp_r = 16'd0;
    wr_mode(3'd6);
    chk("R2 pwm init zero", pin_out, 0);
    cmp_r = 16'd3; cmp_rs = 16'd3;
    wr_mode(3'd6);
    chk("R2 pwm init nonzero", pin_out, 1);
    cnt_step(3); chk("R9 first duty from R", pin_out, 0); chk("R10 no irq", irq, 0);
    cmp_rs = 16'd6; period_hit = 1'b1;
    cnt_step(9); period_hit = 1'b0;
    chk("R9 high at period", pin_out, 1);
    cmp_rs = 16'd2;
    cnt_step(2); chk("R9 mid-period RS ignored", pin_out, 1);
    cnt_step(6); chk("R9 low at duty", pin_out, 0); chk("R10 no irq at duty", irq, 0);
    cmp_rs = 16'd0; period_hit = 1'b1;
    cnt_step(9); period_hit = 1'b0;
    chk("R9 zero duty stays low", pin_out, 0);
  endtask

  task automatic t_off();
    wr_mode(3'd0);
    chk("R3 oe off", pin_oe, 0);
    cmp_r = 16'd1;
    cnt_step(1); chk("R3 no irq", irq, 0);
  endtask

  task automatic t_fault();
    cmp_r = 16'd3; cmp_rs = 16'd5;
    wr_mode(3'd7);
    chk("R2 mode7 init", pin_out, 1);
    tmr_en = 1'b1; fault_n = 1'b0; tmr_cnt = 16'd1;
    tick();
    chk("R11 forced low", pin_out, 0);
    chk("R11 flag set", fault_flag, 1);
    chk("R11 irq", irq, 1);
    tick();
    chk("R11 irq one pulse", irq, 0);
    fault_n = 1'b1; period_hit = 1'b1;
    tick(); period_hit = 1'b0;
    chk("R11 held after release", pin_out, 0);
    chk("R11 flag held", fault_flag, 1);
    wr_mode(3'd7);
    chk("R11 cleared by write", fault_flag, 0);
    chk("R11 pin restarts", pin_out, 1);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_write_gate();
    t_mode1();
    t_mode2();
    t_mode3();
    t_mode4();
    t_mode5();
    t_pwm();
    t_off();
    t_fault();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule